// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the word address presented to a synchronous burst memory. An external address is captured whenever either of two active-low address strobes is low. After that, each cycle with the active-low advance input asserted moves the two least-significant address bits one step through a four-beat burst, while the bits above them keep the captured value.

A runtime order-select input chooses how the two low bits step. In linear order they count up modulo four from the captured value. In interleaved order each beat XORs the captured value with the beat number. Either way, the fifth position is the captured value again. When no strobe is low and advance is deasserted, the address holds, which suspends the burst.

Chip-enable qualification and read/write decoding are done outside this block. The burst length is fixed at four beats. The output address comes from registers, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the address output is all zeros from the next cycle on.
- R2: When `strobe_a_n` or `strobe_b_n` (or both) is sampled low, the next cycle's `addr_out` equals the sampled `ext_addr`, and the burst restarts at beat 0.
- R3: A load takes priority over an advance sampled in the same cycle: the output equals the external address and not the stepped address.
- R4: With `order_sel` = 0 (linear), beat k gives low bits equal to (start + k) mod 4.
- R5: With `order_sel` = 1 (interleaved, also the value to tie off when the order is not controlled), beat k gives low bits equal to start XOR k.
- R6: After the fourth beat, a further advance returns the low bits to the loaded start value.
- R7: Bits [ADDR_W-1:2] never change on an advance; there is no carry out of bit 1.
- R8: With both strobes high and `adv_n` high, the address holds its value (suspend).
- R9: A new external address can be loaded on every consecutive cycle. Each cycle's load shows on the output one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| strobe_a_n | input | 1 | First address strobe, active low |
| strobe_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current memory word address |

## Verification
The assertions check these behaviours on every cycle:
- a strobe captures the external address;
- a load clears the beat index even when advance is also asserted;
- an advance steps the index by exactly one;
- the upper bits never move while no load occurs;
- a suspend leaves the address unchanged.

Only the bench scenarios can show that the two low bits follow the exact linear and XOR sequences, that the sequence wraps back to the start after four beats, and that loads on consecutive cycles and a reset in the middle of a burst behave correctly.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low address bits for a given beat of the burst.
    function automatic beat_t low_bits_for(input beat_t start,
                                           input beat_t beat,
                                           input burst_order_e ord);
        beat_t res;
        if (ord == ORD_LINEAR) res = start + beat;
        else                   res = start ^ beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  advance,
    output beat_t beat
);

    always_ff @(posedge clk) begin
        if (rst)          beat <= '0;
        else if (load)    beat <= '0;
        else if (advance) beat <= beat + beat_t'(1);
    end

    // R3: load wins over a simultaneous advance
    p_load_clears_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat == '0));

    // R6: each advance moves exactly one beat, wrapping modulo four
    p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && advance) |=> (beat == $past(beat) + beat_t'(1)));

    // R8: no load and no advance keeps the beat index
    p_beat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(beat));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst)       base <= '0;
        else if (load) base <= ext_addr;
    end

    // R7: the captured address only changes on a load
    p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base));

endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  burst_order_e      ord,
    output logic [ADDR_W-1:0] addr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    beat_t start;
    assign start = base[BEAT_W-1:0];

    generate
        if (UP_W > 0) begin : g_upper
            assign addr[ADDR_W-1:BEAT_W] = base[ADDR_W-1:BEAT_W];
        end
    endgenerate

    assign addr[BEAT_W-1:0] = low_bits_for(start, beat, ord);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    logic              load;
    logic              advance;
    beat_t             beat;
    logic [ADDR_W-1:0] base;
    burst_order_e      ord;

    assign load    = !strobe_a_n || !strobe_b_n;
    assign advance = !adv_n;
    assign ord     = burst_order_e'(order_sel);

    burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ext_addr (ext_addr),
        .base     (base)
    );

    burst_beat_ctr beat_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .beat    (beat)
    );

    burst_low_map #(.ADDR_W(ADDR_W)) map_i (
        .base (base),
        .beat (beat),
        .ord  (ord),
        .addr (addr_out)
    );

    // R1: reset clears the address
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (addr_out == '0));

    // R2: either strobe captures the external address
    p_strobe_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!strobe_a_n || !strobe_b_n) |=> (addr_out == $past(ext_addr)));

    // R7: upper bits are untouched while no strobe is active
    p_upper_held_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe_a_n && strobe_b_n) |=>
            (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R8: suspend keeps the address when the order select is steady
    p_suspend_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe_a_n && strobe_b_n && adv_n) |=>
            ((order_sel != $past(order_sel)) || $stable(addr_out)));

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int AW   = 16;
    localparam int VW   = 4 + 2 * AW;
    localparam int NVEC = 16;

    function automatic logic [VW-1:0] mk(input logic sa, input logic sb,
                                         input logic adv, input logic md,
                                         input logic [AW-1:0] ext,
                                         input logic [AW-1:0] exp_a);
        return {sa, sb, adv, md, ext, exp_a};
    endfunction

    // fields: strobe_a_n, strobe_b_n, adv_n, order_sel, ext_addr, expected addr
    localparam logic [VW-1:0] VEC [NVEC] = '{
        mk(0, 1, 1, 0, 16'h1231, 16'h1231),  // R2 load via strobe a
        mk(1, 1, 0, 0, 16'h0000, 16'h1232),  // R4 linear beat 1
        mk(1, 1, 0, 0, 16'h0000, 16'h1233),  // R4 linear beat 2
        mk(1, 1, 0, 0, 16'h0000, 16'h1230),  // R7 beat 3, no carry
        mk(1, 1, 0, 0, 16'h0000, 16'h1231),  // R6 wrap to start
        mk(1, 1, 1, 0, 16'h7777, 16'h1231),  // R8 suspend
        mk(1, 0, 1, 1, 16'hABC1, 16'hABC1),  // R2 load via strobe b
        mk(1, 1, 0, 1, 16'h0000, 16'hABC0),  // R5 interleave beat 1
        mk(1, 1, 0, 1, 16'h0000, 16'hABC3),  // R5 interleave beat 2
        mk(1, 1, 0, 1, 16'h0000, 16'hABC2),  // R5 interleave beat 3
        mk(1, 1, 0, 1, 16'h0000, 16'hABC1),  // R6 interleave wrap
        mk(0, 1, 0, 1, 16'h5552, 16'h5552),  // R3 load beats advance
        mk(0, 1, 1, 0, 16'h0003, 16'h0003),  // R9 back-to-back load 1
        mk(1, 0, 1, 0, 16'hFFFF, 16'hFFFF),  // R9 back-to-back load 2
        mk(1, 1, 0, 0, 16'h0000, 16'hFFFC),  // R7 upper held at 3->0
        mk(0, 0, 1, 0, 16'h0100, 16'h0100)   // R2 both strobes
    };

    function automatic string vec_req(input int i);
        case (i)
            1, 2:       return "R4";
            3, 14:      return "R7";
            4, 10:      return "R6";
            5:          return "R8";
            7, 8, 9:    return "R5";
            11:         return "R3";
            12, 13:     return "R9";
            default:    return "R2";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_a_n = 1'b1;
    logic          strobe_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ext_addr   (ext_addr),
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_out   (addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_a);
        n_checks++;
        if (addr_out !== exp_a) begin
            n_fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp_a);
        end
    endtask

    task automatic step(input logic sa, input logic sb, input logic adv,
                        input logic md, input logic [AW-1:0] ext);
        strobe_a_n = sa; strobe_b_n = sb; adv_n = adv;
        order_sel = md; ext_addr = ext;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);                       // reset state
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3], VEC[i][VW-4],
                 VEC[i][2*AW-1:AW]);
            check(vec_req(i), VEC[i][AW-1:0]);
        end

        // R8: long suspend across several cycles while strobes are idle
        step(0, 1, 1, 0, 16'h2342);
        for (int k = 0; k < 3; k++) begin
            step(1, 1, 1, 0, 16'hDEAD);
            check("R8", 16'h2342);
        end

        // R5: interleave from start 2 gives 2,3,0,1
        step(1, 0, 1, 1, 16'h4442);
        step(1, 1, 0, 1, '0); check("R5", 16'h4443);
        step(1, 1, 0, 1, '0); check("R5", 16'h4440);
        step(1, 1, 0, 1, '0); check("R5", 16'h4441);

        // R1: reset mid-burst clears the address
        rst = 1'b1;
        step(1, 1, 0, 0, '0);
        check("R1", '0);
        rst = 1'b0;
        step(1, 1, 1, 0, '0);
        check("R1", '0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule